// File: doc/BRIEF.md
# Accumulator with Rotate Extension Bit

This block is the working register of a small single-accumulator processor: a parameterized accumulator (16 bits by default) paired with a one-bit extension flag. The extension flag catches the carry out of an addition and acts as the seventeenth bit when the accumulator is rotated. A separate controller raises one strobe per clock to pick the operation. The operand comes from a data register input, and an 8-bit input-port value can be merged into the low byte.

The strobes go into a selector that turns them into one named operation. The operations are IDLE, AND, ADD, LOAD, CLEAR, INVERT, ROTR, ROTL, INCR, ECLR, EINV and INPUT. A combinational datapath works out the next accumulator and extension values for that operation. The register process stores them on the rising clock edge, and the output process derives the zero and sign flags from the stored accumulator. The only transition is the one every clock makes, from the current register values to the values the selected operation computes. IDLE takes this transition with unchanged values.

Top module: `acc_unit`

## Requirements
- R1: An active-low reset clears the accumulator and the extension bit to 0.
- R2: The AND strobe replaces the accumulator with its bitwise AND with the data input. The extension bit is unchanged.
- R3: The ADD strobe loads the accumulator with the low bits of accumulator plus data input. The carry out of that sum goes into the extension bit, whether it is 0 or 1.
- R4: The LOAD strobe copies the data input into the accumulator. The CLEAR strobe sets the accumulator to 0. Neither one touches the extension bit.
- R5: The INVERT strobe inverts every accumulator bit. The ECLR strobe sets the extension bit to 0. The EINV strobe inverts the extension bit. ECLR and EINV leave the accumulator unchanged.
- R6: The ROTR strobe shifts the accumulator one place toward bit 0. The old extension bit goes into the top bit, and the old bit 0 goes into the extension bit.
- R7: The ROTL strobe shifts the accumulator one place toward the top bit. The old extension bit goes into bit 0, and the old top bit goes into the extension bit.
- R8: The INCR strobe adds one to the accumulator, wrapping from all-ones to zero. The extension bit is unchanged.
- R9: The INPUT strobe loads accumulator bits 7..0 from the 8-bit input port. Bits above 7 and the extension bit are unchanged.
- R10: When no strobe is active, the accumulator and the extension bit hold their values, whatever the data inputs carry.
- R11: The zero flag is 1 exactly when the stored accumulator is 0. The sign flag equals the accumulator's top bit.
- R12: At most one strobe is active in any clock. If several are raised, the lowest-numbered one takes effect. The order from lowest to highest is AND, ADD, LOAD, CLEAR, INVERT, ROTR, ROTL, INCR, ECLR, EINV, INPUT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dr_in | input | 16 | Data-register operand |
| inpr_in | input | 8 | Input-port byte |
| st_and | input | 1 | AND strobe |
| st_add | input | 1 | ADD strobe |
| st_load | input | 1 | LOAD strobe |
| st_clr | input | 1 | CLEAR strobe |
| st_inv | input | 1 | INVERT strobe |
| st_rotr | input | 1 | ROTR strobe |
| st_rotl | input | 1 | ROTL strobe |
| st_incr | input | 1 | INCR strobe |
| st_eclr | input | 1 | ECLR strobe |
| st_einv | input | 1 | EINV strobe |
| st_input | input | 1 | INPUT strobe |
| acc_q | output | 16 | Accumulator |
| ext_q | output | 1 | Extension bit |
| acc_zero | output | 1 | Accumulator is zero |
| acc_sign | output | 1 | Accumulator top bit |

## Verification
The bench rotates values whose extension bit differs from the bit being shifted out. A design that filled with zero, or that picked up the wrong end bit, then gives a value different from the expected one. It runs an addition that carries and then one that does not carry while the extension bit is already set. A design that only ORed the carry in would leave a stale 1. It increments all-ones so the wrap shows, and checks that the extension bit stays as it was. It merges an input byte over a nonzero high byte, and idles with junk on the data inputs, so a write to bits that should not be touched shows up at the ports.

// File: rtl/acc_pkg.sv
package acc_pkg;
    localparam int ACC_W  = 16;
    localparam int INP_W  = 8;
    localparam int NUM_ST = 11;
    localparam int OP_W   = 4;

    // strobe vector positions; lower index wins on a collision
    localparam int ST_AND   = 0;
    localparam int ST_ADD   = 1;
    localparam int ST_LOAD  = 2;
    localparam int ST_CLR   = 3;
    localparam int ST_INV   = 4;
    localparam int ST_ROTR  = 5;
    localparam int ST_ROTL  = 6;
    localparam int ST_INCR  = 7;
    localparam int ST_ECLR  = 8;
    localparam int ST_EINV  = 9;
    localparam int ST_INPUT = 10;

    // operation code = strobe index + 1, zero means idle
    typedef enum logic [OP_W-1:0] {
        OP_IDLE  = 4'd0,
        OP_AND   = 4'd1,
        OP_ADD   = 4'd2,
        OP_LOAD  = 4'd3,
        OP_CLR   = 4'd4,
        OP_INV   = 4'd5,
        OP_ROTR  = 4'd6,
        OP_ROTL  = 4'd7,
        OP_INCR  = 4'd8,
        OP_ECLR  = 4'd9,
        OP_EINV  = 4'd10,
        OP_INPUT = 4'd11
    } acc_op_e;
endpackage

// File: rtl/acc_op_sel.sv
module acc_op_sel
    import acc_pkg::*;
#(
    parameter int N = NUM_ST
) (
    input  logic [N-1:0] strobes,
    output acc_op_e      op
);
    always_comb begin
        op = OP_IDLE;
        for (int i = N - 1; i >= 0; i--) begin
            if (strobes[i]) begin
                op = acc_op_e'(OP_W'(i + 1));
            end
        end
    end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_pkg::*;
#(
    parameter int W  = ACC_W,
    parameter int IW = INP_W
) (
    input  acc_op_e        op,
    input  logic [W-1:0]   ac,
    input  logic           e,
    input  logic [W-1:0]   dr,
    input  logic [IW-1:0]  inp,
    output logic [W-1:0]   ac_nx,
    output logic           e_nx
);
    localparam int HI_W = W - IW;

    logic [W:0] sum_add;
    logic [W-1:0] sum_inc;

    assign sum_add = {1'b0, ac} + {1'b0, dr};
    assign sum_inc = ac + W'(1);

    always_comb begin
        ac_nx = ac;
        e_nx  = e;
        unique case (op)
            OP_IDLE:  ;
            OP_AND:   ac_nx = ac & dr;
            OP_ADD:   {e_nx, ac_nx} = sum_add;
            OP_LOAD:  ac_nx = dr;
            OP_CLR:   ac_nx = '0;
            OP_INV:   ac_nx = ~ac;
            OP_ROTR:  begin
                ac_nx = {e, ac[W-1:1]};
                e_nx  = ac[0];
            end
            OP_ROTL:  begin
                ac_nx = {ac[W-2:0], e};
                e_nx  = ac[W-1];
            end
            OP_INCR:  ac_nx = sum_inc;
            OP_ECLR:  e_nx = 1'b0;
            OP_EINV:  e_nx = ~e;
            OP_INPUT: ac_nx = {ac[W-1:W-HI_W], inp};
            default:  ;
        endcase
    end
endmodule

// File: rtl/acc_unit.sv
module acc_unit
    import acc_pkg::*;
#(
    parameter int W  = ACC_W,
    parameter int IW = INP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  dr_in,
    input  logic [IW-1:0] inpr_in,
    input  logic          st_and,
    input  logic          st_add,
    input  logic          st_load,
    input  logic          st_clr,
    input  logic          st_inv,
    input  logic          st_rotr,
    input  logic          st_rotl,
    input  logic          st_incr,
    input  logic          st_eclr,
    input  logic          st_einv,
    input  logic          st_input,
    output logic [W-1:0]  acc_q,
    output logic          ext_q,
    output logic          acc_zero,
    output logic          acc_sign
);
    logic [NUM_ST-1:0] strobes;
    acc_op_e           op;
    logic [W-1:0]      ac_nx;
    logic              e_nx;

    always_comb begin
        strobes           = '0;
        strobes[ST_AND]   = st_and;
        strobes[ST_ADD]   = st_add;
        strobes[ST_LOAD]  = st_load;
        strobes[ST_CLR]   = st_clr;
        strobes[ST_INV]   = st_inv;
        strobes[ST_ROTR]  = st_rotr;
        strobes[ST_ROTL]  = st_rotl;
        strobes[ST_INCR]  = st_incr;
        strobes[ST_ECLR]  = st_eclr;
        strobes[ST_EINV]  = st_einv;
        strobes[ST_INPUT] = st_input;
    end

    acc_op_sel #(.N(NUM_ST)) sel_i (
        .strobes (strobes),
        .op      (op)
    );

    acc_datapath #(.W(W), .IW(IW)) dp_i (
        .op    (op),
        .ac    (acc_q),
        .e     (ext_q),
        .dr    (dr_in),
        .inp   (inpr_in),
        .ac_nx (ac_nx),
        .e_nx  (e_nx)
    );

    // register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            ext_q <= 1'b0;
        end else begin
            acc_q <= ac_nx;
            ext_q <= e_nx;
        end
    end

    // output process
    always_comb begin
        acc_zero = (acc_q == '0);
        acc_sign = acc_q[W-1];
    end

    // R12
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(strobes) <= 1);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobes == '0) |=> ($stable(acc_q) && $stable(ext_q)));

    // R3
    add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADD) |=> ({ext_q, acc_q} == ({1'b0, $past(acc_q)} + {1'b0, $past(dr_in)})));

    // R6
    rotr_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ROTR) |=> (ext_q == $past(acc_q[0]) && acc_q[W-1] == $past(ext_q)));

    // R7
    rotl_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ROTL) |=> (ext_q == $past(acc_q[W-1]) && acc_q[0] == $past(ext_q)));

    // R8
    incr_keeps_e_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INCR) |=> $stable(ext_q));

    // R9
    input_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INPUT) |=> (acc_q[W-1:IW] == $past(acc_q[W-1:IW])
                              && acc_q[IW-1:0] == $past(inpr_in) && $stable(ext_q)));
endmodule

// File: tb/acc_unit_tb.sv
module acc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] dr_in = '0;
    logic [7:0]  inpr_in = '0;
    logic [10:0] stb = '0;
    logic [15:0] acc_q;
    logic        ext_q, acc_zero, acc_sign;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    acc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .dr_in(dr_in), .inpr_in(inpr_in),
        .st_and(stb[0]), .st_add(stb[1]), .st_load(stb[2]), .st_clr(stb[3]),
        .st_inv(stb[4]), .st_rotr(stb[5]), .st_rotl(stb[6]), .st_incr(stb[7]),
        .st_eclr(stb[8]), .st_einv(stb[9]), .st_input(stb[10]),
        .acc_q(acc_q), .ext_q(ext_q), .acc_zero(acc_zero), .acc_sign(acc_sign)
    );

    // {op code (0 idle, else strobe index+1), dr, inpr, expected acc, expected ext, requirement}
    localparam int NV = 25;
    localparam logic [48:0] VEC [NV] = '{
        {4'd3,  16'h1234, 8'h00, 16'h1234, 1'b0, 4'd4},   // R4 load
        {4'd1,  16'h00FF, 8'h00, 16'h0034, 1'b0, 4'd2},   // R2 and
        {4'd3,  16'hF0F0, 8'h00, 16'hF0F0, 1'b0, 4'd4},   // R4
        {4'd2,  16'h1F10, 8'h00, 16'h1000, 1'b1, 4'd3},   // R3 carry out
        {4'd0,  16'hFFFF, 8'hFF, 16'h1000, 1'b1, 4'd10},  // R10 idle with junk
        {4'd2,  16'h0001, 8'h00, 16'h1001, 1'b0, 4'd3},   // R3 no carry clears E
        {4'd5,  16'h0000, 8'h00, 16'hEFFE, 1'b0, 4'd5},   // R5 invert
        {4'd10, 16'hAAAA, 8'h00, 16'hEFFE, 1'b1, 4'd5},   // R5 einv
        {4'd6,  16'h0000, 8'h00, 16'hF7FF, 1'b0, 4'd6},   // R6 rotr
        {4'd6,  16'h0000, 8'h00, 16'h7BFF, 1'b1, 4'd6},   // R6
        {4'd7,  16'h0000, 8'h00, 16'hF7FF, 1'b0, 4'd7},   // R7 rotl
        {4'd7,  16'h0000, 8'h00, 16'hEFFE, 1'b1, 4'd7},   // R7
        {4'd9,  16'h5555, 8'h00, 16'hEFFE, 1'b0, 4'd5},   // R5 eclr
        {4'd3,  16'hFFFF, 8'h00, 16'hFFFF, 1'b0, 4'd4},   // R4
        {4'd10, 16'h0000, 8'h00, 16'hFFFF, 1'b1, 4'd5},   // R5
        {4'd8,  16'h0000, 8'h00, 16'h0000, 1'b1, 4'd8},   // R8 wrap, E kept
        {4'd11, 16'hFFFF, 8'hA5, 16'h00A5, 1'b1, 4'd9},   // R9
        {4'd3,  16'h1200, 8'h00, 16'h1200, 1'b1, 4'd4},   // R4
        {4'd11, 16'h0000, 8'h3C, 16'h123C, 1'b1, 4'd9},   // R9 high byte kept
        {4'd4,  16'hFFFF, 8'h00, 16'h0000, 1'b1, 4'd4},   // R4 clear
        {4'd5,  16'h0000, 8'h00, 16'hFFFF, 1'b1, 4'd5},   // R5
        {4'd7,  16'h0000, 8'h00, 16'hFFFF, 1'b1, 4'd7},   // R7
        {4'd9,  16'h0000, 8'h00, 16'hFFFF, 1'b0, 4'd5},   // R5
        {4'd6,  16'h0000, 8'h00, 16'h7FFF, 1'b1, 4'd6},   // R6
        {4'd8,  16'h0000, 8'h00, 16'h8000, 1'b1, 4'd8}    // R8
    };

    task automatic check(input string req, input logic [15:0] exp_ac, input logic exp_e);
        n_run++;
        if (acc_q !== exp_ac || ext_q !== exp_e) begin
            n_fail++;
            $display("FAIL %s: acc=%h ext=%b expected acc=%h ext=%b", req, acc_q, ext_q, exp_ac, exp_e);
        end
        // R11 flags follow the stored value
        n_run++;
        if (acc_zero !== (exp_ac == 16'h0) || acc_sign !== exp_ac[15]) begin
            n_fail++;
            $display("FAIL R11: zero=%b sign=%b expected zero=%b sign=%b",
                     acc_zero, acc_sign, (exp_ac == 16'h0), exp_ac[15]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 16'h0000, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [3:0] opc;
            opc     = VEC[i][48:45];
            dr_in   = VEC[i][44:29];
            inpr_in = VEC[i][28:21];
            stb     = (opc == 4'd0) ? 11'd0 : (11'd1 << (opc - 4'd1));
            @(negedge clk);
            stb = '0;
            check($sformatf("R%0d vector %0d", VEC[i][3:0], i), VEC[i][20:5], VEC[i][4]);
        end

        // R10: several idle cycles with changing operands
        for (int k = 0; k < 4; k++) begin
            dr_in   = 16'(k * 16'h1111);
            inpr_in = 8'(k * 8'h33);
            @(negedge clk);
            check("R10 idle hold", 16'h8000, 1'b1);
        end

        // R1: reset from a nonzero state
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset again", 16'h0000, 1'b0);
        rst_n = 1'b1;

        // R3: largest sum
        dr_in = 16'hFFFF; stb = 11'd1 << 2; @(negedge clk);
        stb = 11'd1 << 1; @(negedge clk);
        stb = '0;
        check("R3 FFFF+FFFF", 16'hFFFE, 1'b1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule